// File: doc/BRIEF.md
# Debug-Port Fast Memory Download Engine

This block sits behind a serial debug port and turns a stream of 32-bit words coming from a host into consecutive word writes on a system-memory write port. The host first loads an address register with the first destination address minus the word size (4 bytes). It then issues a start command. From then on, every data word it sends is held in a data register. The address register is stepped up by 4, and the word is written to the stepped address. There is no fixed word count: the sequence runs until the host sends an end command. That end command must be followed by one more data word. The engine consumes that word and never writes it to memory.

The host side is a valid/ready channel that carries a 2-bit kind and a data word. The memory side is a valid/ready write port that carries a word address and the data. A word that has been accepted is held at the write port until memory takes it. While a write is outstanding the host channel is back-pressured, so no word is lost or written twice. A counter reports how many words the current download has written.

Top module: `dl_fast_download`

## Requirements
- R1: Kind encoding on `host_kind`: 2'b00 data, 2'b01 load address, 2'b10 start, 2'b11 end. A load-address item accepted while the engine is idle copies `host_word` into the address register.
- R2: A start item accepted while idle raises `active` in the following cycle and clears `words_written` to zero.
- R3: Each data item accepted while a download is running produces exactly one memory write. Its address is the previous address register value plus 4 (pre-increment), and its data is the accepted word. So the first write goes to the loaded value plus 4.
- R4: Once `wr_valid` is high, `wr_addr` and `wr_data` stay constant and `wr_valid` stays high until `wr_ready` is seen. `host_ready` is low for as long as `wr_valid` is high.
- R5: An end item accepted during a download makes the engine wait for exactly one more data item. That item is consumed without any memory write, and `active` then drops.
- R6: `words_written` increases by one on each completed write handshake (`wr_valid` and `wr_ready` both high) and holds otherwise. The discarded trailing word is not counted.
- R7: Data and end items accepted while idle cause no write and no state change. Load-address and start items accepted during a download change neither the address sequence nor the count.
- R8: A synchronous active-low reset returns the engine to idle with `wr_valid` low and `words_written` zero. It leaves the address register unchanged, so a later start without a new load continues from the retained address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Host item present |
| host_ready | output | 1 | Engine can take a host item this cycle |
| host_kind | input | 2 | Item kind: 00 data, 01 load address, 10 start, 11 end |
| host_word | input | DATA_W | Data word or address value |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | DATA_W | Word to write |
| words_written | output | CNT_W | Completed writes in the current download |
| active | output | 1 | A download is running, including the trailing-word wait |

## Verification
A corrupted address register shows at the port on the very next write, as a `wr_addr` that is off from the expected pre-incremented sequence. A state machine stuck in the wrong state shows either as a write for the discarded trailing word or for an idle-time data word, or as `active` staying high after the trailing word. A lost or duplicated word under memory stalls shows as a missing or extra write handshake. The bench compares every handshake against a queue of expected address/data pairs within the same cycle, and compares `words_written` with its own count once the queue drains.

// File: rtl/dl_pkg.sv
// Package: shared types for the fast download engine.
// Assumes a 2-bit item kind on the host channel.
package dl_pkg;
    typedef enum logic [1:0] {
        KIND_DATA  = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_START = 2'b10,
        KIND_END   = 2'b11
    } dl_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DATA,
        ST_WRITE,
        ST_DRAIN_LAST
    } dl_state_e;

    // One strobe per item kind, valid only in a cycle where an item is taken.
    typedef struct packed {
        logic data;
        logic load;
        logic start;
        logic stop;
    } dl_strobe_t;
endpackage

// File: rtl/dl_cmd_decode.sv
// Module: dl_cmd_decode
// Turns a host item handshake into one strobe per item kind.
// Assumes host_ready already reflects whether the engine can take an item.
module dl_cmd_decode
    import dl_pkg::*;
(
    input  logic       host_valid,
    input  logic       host_ready,
    input  logic [1:0] host_kind,
    output dl_strobe_t strb
);
    logic fire;

    assign fire = host_valid && host_ready;

    // Raise the strobe that matches the kind of the item being taken.
    always_comb begin
        strb = '0;
        if (fire) begin
            case (dl_kind_e'(host_kind))
                KIND_DATA:  strb.data  = 1'b1;
                KIND_LOAD:  strb.load  = 1'b1;
                KIND_START: strb.start = 1'b1;
                KIND_END:   strb.stop  = 1'b1;
                default:    strb       = '0;
            endcase
        end
    end
endmodule

// File: rtl/dl_fsm.sv
// Module: dl_fsm
// Sequences a download: idle, wait for data, write, wait for the trailing word.
// Assumes strobes come from dl_cmd_decode using host_ready from this module.
module dl_fsm
    import dl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dl_strobe_t strb,
    input  logic       wr_ready,
    output logic       host_ready,
    output logic       wr_valid,
    output logic       wr_done,
    output logic       load_addr,
    output logic       accept_data,
    output logic       clear_cnt,
    output logic       active
);
    dl_state_e state_q;
    dl_state_e state_d;

    // Next-state selection from the current state and the taken item.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (strb.start) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA: begin
                if (strb.data)      state_d = ST_WRITE;
                else if (strb.stop) state_d = ST_DRAIN_LAST;
            end
            ST_WRITE:      if (wr_ready) state_d = ST_WAIT_DATA;
            ST_DRAIN_LAST: if (strb.data) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign host_ready  = (state_q != ST_WRITE);
    assign wr_valid    = (state_q == ST_WRITE);
    assign wr_done     = wr_valid && wr_ready;
    assign load_addr   = strb.load  && (state_q == ST_IDLE);
    assign clear_cnt   = strb.start && (state_q == ST_IDLE);
    assign accept_data = strb.data  && (state_q == ST_WAIT_DATA);
    assign active      = (state_q != ST_IDLE);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid);
    assert_write_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_data |=> wr_valid);
    assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN_LAST && strb.data) |=> (state_q == ST_IDLE && !wr_valid));
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cnt |=> (state_q == ST_WAIT_DATA));
    assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !strb.start) |=> (state_q == ST_IDLE));
    assert_reset_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == ST_IDLE));
endmodule

// File: rtl/dl_datapath.sv
// Module: dl_datapath
// Holds the pre-biased address register and the temporary data register.
// Assumes load_addr and accept_data are never high together. Neither
// register is reset: the address survives reset by design.
module dl_datapath #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              accept_data,
    input  logic              wr_valid,
    input  logic              wr_ready,
    input  logic [DATA_W-1:0] host_word,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int STEP = DATA_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] load_val;

    // Fit the host word to the address width.
    generate
        if (ADDR_W <= DATA_W) begin : g_trunc
            assign load_val = host_word[ADDR_W-1:0];
        end else begin : g_extend
            assign load_val = {{(ADDR_W - DATA_W){1'b0}}, host_word};
        end
    endgenerate

    // Address register: loaded by the host, pre-incremented per data word.
    always_ff @(posedge clk) begin
        if (load_addr)        addr_q <= load_val;
        else if (accept_data) addr_q <= addr_q + ADDR_W'(STEP);
    end

    // Temporary data register: captures each accepted data word.
    always_ff @(posedge clk) begin
        if (accept_data) data_q <= host_word;
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_addr |=> (addr_q == $past(load_val)));
    assert_preinc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_data |=> (addr_q == $past(addr_q) + ADDR_W'(STEP)));
    assert_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/dl_word_counter.sv
// Module: dl_word_counter
// Counts completed memory writes of the current download.
// Assumes clear and incr are never high together (start only in idle).
module dl_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             incr,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    // Counter with synchronous reset, clear on start, wrap on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count_q <= '0;
        else if (incr)       count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!incr && !clear) |=> $stable(count_q));
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !clear) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/dl_fast_download.sv
// Module: dl_fast_download (top)
// Debug-port fast memory download engine: host items in, word writes out.
// Assumes the host loads the address (first target minus 4) before start.
module dl_fast_download #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [1:0]        host_kind,
    input  logic [DATA_W-1:0] host_word,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  words_written,
    output logic              active
);
    import dl_pkg::*;

    dl_strobe_t strb;
    logic       wr_done;
    logic       load_addr;
    logic       accept_data;
    logic       clear_cnt;

    dl_cmd_decode i_decode (
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_kind  (host_kind),
        .strb       (strb)
    );

    dl_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb        (strb),
        .wr_ready    (wr_ready),
        .host_ready  (host_ready),
        .wr_valid    (wr_valid),
        .wr_done     (wr_done),
        .load_addr   (load_addr),
        .accept_data (accept_data),
        .clear_cnt   (clear_cnt),
        .active      (active)
    );

    dl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_addr   (load_addr),
        .accept_data (accept_data),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .host_word   (host_word),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    dl_word_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_cnt),
        .incr  (wr_done),
        .count (words_written)
    );

    assert_no_take_during_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !host_ready);
endmodule

// File: tb/test_dl_fast_download.sv
module test_dl_fast_download;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_DATA = 2'b00, K_LOAD = 2'b01, K_START = 2'b10, K_END = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic [1:0]  host_kind = K_DATA;
    logic [31:0] host_word = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [15:0] words_written;
    logic        active;

    dl_fast_download i_dl_fast_download (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_kind(host_kind), .host_word(host_word), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .words_written(words_written), .active(active)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int ready_pct = 100;
    string cur_req = "R7";
    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    logic [31:0] m_addr = '0;
    int m_mode = 0;
    int m_count = 0;
    bit prev_stall = 0;
    logic [31:0] prev_addr, prev_data;

    function automatic logic [31:0] next_addr(input logic [31:0] a);
        return a + 32'd4;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, inspect the handshakes due at the next edge.
    task automatic tick(input bit v, input logic [1:0] k, input logic [31:0] w, output bit fire);
        @(negedge clk);
        host_valid = v; host_kind = k; host_word = w;
        wr_ready = ($urandom_range(99) < ready_pct);
        #1;
        if (prev_stall) begin
            chk(wr_valid, "R4", "valid held under stall", wr_valid, 1);
            chk(wr_addr == prev_addr && wr_data == prev_data, "R4", "addr held under stall",
                wr_addr, prev_addr);
        end
        if (wr_valid) chk(!host_ready, "R4", "host blocked during write", host_ready, 0);
        if (wr_valid && wr_ready) begin
            if (exp_addr_q.size() == 0) begin
                chk(0, cur_req, "unexpected write", wr_addr, 0);
            end else begin
                logic [31:0] ea, ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                chk(wr_addr == ea, "R3", "write address", wr_addr, ea);
                chk(wr_data == ed, "R3", "write data", wr_data, ed);
            end
        end
        prev_stall = wr_valid && !wr_ready;
        prev_addr = wr_addr;
        prev_data = wr_data;
        fire = v && host_ready;
    endtask

    task automatic idle(input int n);
        bit f;
        for (int i = 0; i < n; i++) tick(0, K_DATA, '0, f);
    endtask

    // Send one item and update the bench model from the requirements.
    task automatic send(input logic [1:0] k, input logic [31:0] w);
        bit f = 0;
        while (!f) tick(1, k, w, f);
        case (k)
            K_LOAD:  if (m_mode == 0) m_addr = w;
            K_START: if (m_mode == 0) begin m_mode = 1; m_count = 0; end
            K_END:   if (m_mode == 1) m_mode = 2;
            default: begin
                if (m_mode == 1) begin
                    m_addr = next_addr(m_addr);
                    exp_addr_q.push_back(m_addr);
                    exp_data_q.push_back(w);
                    m_count++;
                end else if (m_mode == 2) begin
                    m_mode = 0;
                end
            end
        endcase
    endtask

    task automatic flush_and_count(input string req);
        int n = 0;
        int save = ready_pct;
        ready_pct = 100;
        while (exp_addr_q.size() != 0 && n < 200) begin idle(1); n++; end
        idle(1);
        ready_pct = save;
        @(negedge clk);
        prev_stall = 0;
        chk(exp_addr_q.size() == 0, req, "pending writes drained", exp_addr_q.size(), 0);
        chk(words_written == 16'(m_count), "R6", "words_written", words_written, m_count);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 0; host_valid = 0; wr_ready = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        exp_addr_q.delete(); exp_data_q.delete();
        m_mode = 0; m_count = 0; prev_stall = 0;
        chk(!active, "R8", "active after reset", active, 0);
        chk(!wr_valid, "R8", "wr_valid after reset", wr_valid, 0);
        chk(words_written == 0, "R8", "count after reset", words_written, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1, R2, R3: directed download of three words at full speed.
        cur_req = "R3";
        send(K_LOAD, 32'h0000_1000);
        send(K_START, '0);
        @(negedge clk);
        chk(active, "R2", "active after start", active, 1);
        send(K_DATA, 32'hAAAA_0001);
        send(K_DATA, 32'hAAAA_0002);
        send(K_DATA, 32'hAAAA_0003);
        flush_and_count("R1");
        // R5: end plus trailing word, trailing word must not be written.
        cur_req = "R5";
        send(K_END, '0);
        send(K_DATA, 32'hDEAD_BEEF);
        idle(3);
        @(negedge clk);
        chk(!active, "R5", "idle after trailing word", active, 0);
        chk(words_written == 16'd3, "R5", "trailing not counted", words_written, 3);

        // R4: memory stalls for several cycles.
        cur_req = "R4";
        send(K_START, '0);
        ready_pct = 0;
        send(K_DATA, 32'h5555_0001);
        idle(6);
        ready_pct = 100;
        flush_and_count("R4");
        send(K_END, '0);
        send(K_DATA, 32'h0);
        idle(2);

        // R7: data and end while idle are ignored.
        cur_req = "R7";
        send(K_DATA, 32'h7777_7777);
        send(K_END, '0);
        idle(3);
        @(negedge clk);
        chk(!active, "R7", "still idle", active, 0);
        chk(words_written == 16'd1, "R7", "count untouched while idle", words_written, 1);
        // R2 clears count; R7 load/start during a download are ignored.
        send(K_START, '0);
        @(negedge clk);
        chk(words_written == 0, "R2", "count cleared by start", words_written, 0);
        send(K_LOAD, 32'h0000_9000);
        send(K_START, '0);
        send(K_DATA, 32'h1234_5678);
        flush_and_count("R7");

        // R8: reset mid-download keeps the address register.
        do_reset();
        cur_req = "R8";
        send(K_START, '0);
        send(K_DATA, 32'h8888_0001);
        flush_and_count("R8");
        send(K_END, '0);
        send(K_DATA, 32'h0);

        // R5/R6: zero-length download.
        cur_req = "R5";
        send(K_START, '0);
        send(K_END, '0);
        send(K_DATA, 32'hFFFF_FFFF);
        idle(2);
        flush_and_count("R5");

        // Random downloads with random stalls and gaps.
        for (int s = 0; s < 10; s++) begin
            int n;
            cur_req = "R3";
            ready_pct = 20 + $urandom_range(80);
            send(K_LOAD, {$urandom_range(32'h0FFF_FFFF), 2'b00});
            send(K_START, '0);
            n = $urandom_range(24);
            for (int i = 0; i < n; i++) begin
                send(K_DATA, $urandom());
                if ($urandom_range(3) == 0) idle($urandom_range(3));
            end
            send(K_END, '0);
            cur_req = "R5";
            send(K_DATA, $urandom());
            flush_and_count("R6");
            chk(!active, "R5", "idle after random download", active, 0);
            chk(m_count == n, "R6", "model count", m_count, n);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule